// File: doc/BRIEF.md
# Effective Address Generator

This block turns an addressing-mode code, up to two operand bytes, the two index registers and the program counter into the 16-bit address that an 8-bit processor would access. Direct modes (zero page, zero page with X or Y, absolute, absolute with X or Y, relative) are resolved from the request alone. Pointer modes (absolute indirect, X-pre-indexed indirect, Y-post-indexed indirect) first fetch a two-byte pointer through a small read port whose data returns one cycle after the read strobe.

A request is accepted in any cycle where `reqValid` is high and `busy` is low. The result appears with a one-cycle `eaValid` pulse, together with `eaErr` for modes that have no address or whose result is undefined. Only one request is handled at a time.

Top module: `ea_gen`

## Requirements
- R1: During and after reset, before any request, `busy`, `eaValid` and `memRd` are low.
- R2: Mode codes are 0 accumulator, 1 immediate, 2 implied, 3 relative, 4 absolute, 5 zero page, 6 absolute indirect, 7 absolute+X, 8 absolute+Y, 9 zero page+X, 10 zero page+Y, 11 X-pre-indexed indirect, 12 Y-post-indexed indirect. A request is taken at a rising edge where `reqValid` is high and `busy` is low. A direct mode delivers its result in the cycle right after that edge. A request raised while `busy` is high is ignored and produces no result and no read.
- R3: Zero-page mode returns `{8'h00, reqOperand[7:0]}` and absolute mode returns `reqOperand`.
- R4: Zero-page+X and zero-page+Y add the index to `reqOperand[7:0]` modulo 256, so the high byte is always 8'h00.
- R5: Absolute+X and absolute+Y add the zero-extended index to the 16-bit operand with full carry, wrapping modulo 65536.
- R6: Relative mode adds `reqOperand[7:0]`, sign-extended from its bit 7, to `progCtr`.
- R7: X-pre-indexed indirect reads first at `{8'h00, op+X}` and then at `{8'h00, op+X+1}`, with both low bytes taken modulo 256. It returns `{second byte, first byte}`. `memRd` is high for exactly the two cycles after acceptance, and the result comes three cycles after that.
- R8: Y-post-indexed indirect reads at `{8'h00, op}` and then `{8'h00, op+1}`, with the low byte wrapping in page zero. It returns the fetched pointer plus zero-extended Y, modulo 65536.
- R9: Absolute indirect reads at `reqOperand` and then `reqOperand+1`, and returns `{second byte, first byte}`.
- R10: Absolute indirect with `reqOperand[7:0] == 8'hFF` performs no read. It returns `eaErr` high and `eaAddr` 0 in the cycle after acceptance.
- R11: Accumulator, immediate, implied and codes 13 to 15 return `eaErr` high and `eaAddr` 0 in the cycle after acceptance. All other accepted modes return `eaErr` low.
- R12: `eaValid` lasts one cycle, and `busy` is high from the cycle after acceptance through the `eaValid` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqMode | input | 4 | Addressing-mode code |
| reqOperand | input | 16 | Operand bytes, first byte in the low half |
| idxX | input | 8 | X index value |
| idxY | input | 8 | Y index value |
| progCtr | input | 16 | Program counter for relative targets |
| busy | output | 1 | Request in progress |
| memAddr | output | 16 | Pointer read address |
| memRd | output | 1 | Pointer read strobe |
| memData | input | 8 | Read data, one cycle after the strobe |
| eaValid | output | 1 | Result pulse |
| eaAddr | output | 16 | Effective address |
| eaErr | output | 1 | No address or undefined result |

## Verification
The bench builds the block with its default byte width of 8, which gives a 16-bit address. With that width, the page-zero wrap at 8'hFF, the carry out of the low byte into the high byte for indexed absolute, and the wrap past 16'hFFFF all fall inside a short directed list. The bench's memory returns an address-dependent byte. Because of this, a swap of the low and high pointer bytes, or a read from the wrong address, shows up both in the result and in the read-address queue.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [3:0] {
    M_ACC    = 4'd0,
    M_IMM    = 4'd1,
    M_IMP    = 4'd2,
    M_REL    = 4'd3,
    M_ABS    = 4'd4,
    M_ZP     = 4'd5,
    M_IND    = 4'd6,
    M_ABSX   = 4'd7,
    M_ABSY   = 4'd8,
    M_ZPX    = 4'd9,
    M_ZPY    = 4'd10,
    M_IDXIND = 4'd11,
    M_INDIDX = 4'd12
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_WAIT,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic accept;   // latch request fields
    logic direct;   // load result computed from the request
    logic grabLo;   // capture low pointer byte
    logic grabHi;   // capture high pointer byte and form result
    logic selHi;    // drive second pointer address
  } strobe_t;

endpackage

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    needFetch,
  input  logic    isUndef,
  output strobe_t strb,
  output logic    busy,
  output logic    memRd,
  output logic    eaValid
);

  state_e state, nextState;
  logic   accept;
  logic   goFetch;

  assign accept  = reqValid && (state == ST_IDLE);
  assign goFetch = needFetch && !isUndef;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (accept) nextState = goFetch ? ST_PTR_LO : ST_DONE;
      ST_PTR_LO: nextState = ST_PTR_HI;
      ST_PTR_HI: nextState = ST_WAIT;
      ST_WAIT:   nextState = ST_DONE;
      ST_DONE:   nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb        = '0;
    strb.accept = accept;
    strb.direct = accept && !goFetch;
    strb.grabLo = (state == ST_PTR_HI);
    strb.grabHi = (state == ST_WAIT);
    strb.selHi  = (state == ST_PTR_HI);
  end

  assign busy    = (state != ST_IDLE);
  assign memRd   = (state == ST_PTR_LO) || (state == ST_PTR_HI);
  assign eaValid = (state == ST_DONE);

endmodule

// File: rtl/ea_gen_dpath.sv
module ea_gen_dpath
  import ea_gen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [3:0]            reqMode,
  input  logic [2*DATA_W-1:0]   reqOperand,
  input  logic [DATA_W-1:0]     idxX,
  input  logic [DATA_W-1:0]     idxY,
  input  logic [2*DATA_W-1:0]   progCtr,
  input  logic [DATA_W-1:0]     memData,
  output logic                  needFetch,
  output logic                  isUndef,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0]   eaAddr,
  output logic                  eaErr
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] LAST_IN_PAGE = {DATA_W{1'b1}};

  function automatic logic [ADDR_W-1:0] pageZero(input logic [DATA_W-1:0] b);
    return {{DATA_W{1'b0}}, b};
  endfunction

  logic [DATA_W-1:0] opLo;
  logic [DATA_W-1:0] sumX;
  logic [DATA_W-1:0] sumY;
  logic [DATA_W-1:0] sumXNext;
  logic [DATA_W-1:0] opLoNext;
  logic [ADDR_W-1:0] relOffset;
  logic [ADDR_W-1:0] directAddr;
  logic [ADDR_W-1:0] ptrLoNext;
  logic [ADDR_W-1:0] ptrHiNext;

  logic [ADDR_W-1:0] ptrLoR;
  logic [ADDR_W-1:0] ptrHiR;
  logic [DATA_W-1:0] yR;
  logic              addYR;
  logic [DATA_W-1:0] loR;
  logic [ADDR_W-1:0] resultR;
  logic              errR;

  assign opLo      = reqOperand[DATA_W-1:0];
  assign sumX      = opLo + idxX;
  assign sumY      = opLo + idxY;
  assign sumXNext  = sumX + 1'b1;
  assign opLoNext  = opLo + 1'b1;
  assign relOffset = {{DATA_W{opLo[DATA_W-1]}}, opLo};

  // Request classification
  always_comb begin
    needFetch = 1'b0;
    isUndef   = 1'b0;
    case (reqMode)
      M_REL, M_ABS, M_ZP, M_ABSX, M_ABSY, M_ZPX, M_ZPY: ;
      M_IND: begin
        needFetch = 1'b1;
        isUndef   = (opLo == LAST_IN_PAGE);
      end
      M_IDXIND, M_INDIDX: needFetch = 1'b1;
      default: isUndef = 1'b1;
    endcase
  end

  // Direct address formation
  always_comb begin
    directAddr = '0;
    case (reqMode)
      M_REL:  directAddr = progCtr + relOffset;
      M_ABS:  directAddr = reqOperand;
      M_ZP:   directAddr = pageZero(opLo);
      M_ABSX: directAddr = reqOperand + pageZero(idxX);
      M_ABSY: directAddr = reqOperand + pageZero(idxY);
      M_ZPX:  directAddr = pageZero(sumX);
      M_ZPY:  directAddr = pageZero(sumY);
      default: directAddr = '0;
    endcase
  end

  // Pointer location for the fetch modes
  always_comb begin
    ptrLoNext = reqOperand;
    ptrHiNext = reqOperand + 1'b1;
    case (reqMode)
      M_IDXIND: begin
        ptrLoNext = pageZero(sumX);
        ptrHiNext = pageZero(sumXNext);
      end
      M_INDIDX: begin
        ptrLoNext = pageZero(opLo);
        ptrHiNext = pageZero(opLoNext);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrLoR  <= '0;
      ptrHiR  <= '0;
      yR      <= '0;
      addYR   <= 1'b0;
      loR     <= '0;
      resultR <= '0;
      errR    <= 1'b0;
    end else begin
      if (strb.accept) begin
        ptrLoR <= ptrLoNext;
        ptrHiR <= ptrHiNext;
        yR     <= idxY;
        addYR  <= (reqMode == M_INDIDX);
        errR   <= isUndef;
      end
      if (strb.direct) begin
        resultR <= isUndef ? '0 : directAddr;
      end
      if (strb.grabLo) begin
        loR <= memData;
      end
      if (strb.grabHi) begin
        resultR <= {memData, loR} + (addYR ? pageZero(yR) : '0);
      end
    end
  end

  assign memAddr = strb.selHi ? ptrHiR : ptrLoR;
  assign eaAddr  = resultR;
  assign eaErr   = errR;

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [3:0]          reqMode,
  input  logic [2*DATA_W-1:0] reqOperand,
  input  logic [DATA_W-1:0]   idxX,
  input  logic [DATA_W-1:0]   idxY,
  input  logic [2*DATA_W-1:0] progCtr,
  output logic                busy,
  output logic [2*DATA_W-1:0] memAddr,
  output logic                memRd,
  input  logic [DATA_W-1:0]   memData,
  output logic                eaValid,
  output logic [2*DATA_W-1:0] eaAddr,
  output logic                eaErr
);

  strobe_t strb;
  logic    needFetch;
  logic    isUndef;

  ea_gen_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .needFetch (needFetch),
    .isUndef   (isUndef),
    .strb      (strb),
    .busy      (busy),
    .memRd     (memRd),
    .eaValid   (eaValid)
  );

  ea_gen_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqMode    (reqMode),
    .reqOperand (reqOperand),
    .idxX       (idxX),
    .idxY       (idxY),
    .progCtr    (progCtr),
    .memData    (memData),
    .needFetch  (needFetch),
    .isUndef    (isUndef),
    .memAddr    (memAddr),
    .eaAddr     (eaAddr),
    .eaErr      (eaErr)
  );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_gen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [3:0]          reqMode,
  input logic                busy,
  input logic                memRd,
  input logic                eaValid,
  input logic [2*DATA_W-1:0] eaAddr,
  input logic                eaErr
);

  localparam int ADDR_W = 2 * DATA_W;

  logic takeReq;
  assign takeReq = reqValid && !busy;

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |=> !eaValid);

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |-> busy);

  assert_rd_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busy);

  assert_rd_pair_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRd) |=> memRd);

  assert_rd_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |=> !memRd);

  assert_zp_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && (reqMode == M_ZPX || reqMode == M_ZPY))
      |=> (eaValid && eaAddr[ADDR_W-1:DATA_W] == '0 && !eaErr));

  assert_no_addr_R11: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && (reqMode == M_ACC || reqMode == M_IMM || reqMode == M_IMP))
      |=> (eaValid && eaErr && eaAddr == '0));

endmodule

bind ea_gen ea_gen_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [3:0]        reqMode = '0;
  logic [ADDR_W-1:0] reqOperand = '0;
  logic [DATA_W-1:0] idxX = '0;
  logic [DATA_W-1:0] idxY = '0;
  logic [ADDR_W-1:0] progCtr = '0;
  logic              busy;
  logic [ADDR_W-1:0] memAddr;
  logic              memRd;
  logic [DATA_W-1:0] memData = '0;
  logic              eaValid;
  logic [ADDR_W-1:0] eaAddr;
  logic              eaErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqOperand(reqOperand), .idxX(idxX), .idxY(idxY), .progCtr(progCtr),
    .busy(busy), .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .eaValid(eaValid), .eaAddr(eaAddr), .eaErr(eaErr)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              err;
    int                dueCyc;
    string             tag;
  } expect_t;

  expect_t           expQ[$];
  logic [ADDR_W-1:0] rdQ[$];
  int compared = 0;
  int mismatched = 0;
  int extraCount = 0;
  int cyc = 0;
  bit finished = 1'b0;

  function automatic logic [DATA_W-1:0] memFn(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] v;
    v = a[7:0] * 8'd7;
    return v + a[15:8] + 8'h13;
  endfunction

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memRd) memData <= memFn(memAddr);
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memRd) begin
        if (rdQ.size() == 0) begin
          extraCount++;
          check(1'b0, "R2", "unexpected read", {16'h0, memAddr}, 32'h0);
        end else begin
          logic [ADDR_W-1:0] ea;
          ea = rdQ.pop_front();
          check(memAddr == ea, "R7", "read address", {16'h0, memAddr}, {16'h0, ea});
        end
      end
      if (eaValid) begin
        if (expQ.size() == 0) begin
          extraCount++;
          check(1'b0, "R2", "unexpected result", {16'h0, eaAddr}, 32'h0);
        end else begin
          expect_t e;
          e = expQ.pop_front();
          check(eaAddr == e.addr, e.tag, "address", {16'h0, eaAddr}, {16'h0, e.addr});
          check(eaErr == e.err, e.tag, "error flag", {31'h0, eaErr}, {31'h0, e.err});
          check(cyc == e.dueCyc, e.tag, "latency", cyc, e.dueCyc);
          check(busy == 1'b1, "R12", "busy during result", {31'h0, busy}, 32'h1);
        end
      end
    end
  end

  // Driver: lat is 0 for direct and error results, 3 for pointer fetches
  task automatic issue(input logic [3:0] m, input logic [ADDR_W-1:0] op,
                       input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                       input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] expA,
                       input logic expE, input int lat, input string tag);
    expect_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.addr = expA; e.err = expE; e.dueCyc = cyc + 1 + lat; e.tag = tag;
    expQ.push_back(e);
    reqMode = m; reqOperand = op; idxX = x; idxY = y; progCtr = pc;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic fetchExp(input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi);
    rdQ.push_back(lo);
    rdQ.push_back(hi);
  endtask

  function automatic logic [ADDR_W-1:0] ptrOf(input logic [ADDR_W-1:0] lo,
                                              input logic [ADDR_W-1:0] hi);
    return {memFn(hi), memFn(lo)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy in reset", {31'h0, busy}, 32'h0);
    check(eaValid == 1'b0, "R1", "valid in reset", {31'h0, eaValid}, 32'h0);
    check(memRd == 1'b0, "R1", "read in reset", {31'h0, memRd}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !eaValid && !memRd, "R1", "idle after reset",
          {29'h0, busy, eaValid, memRd}, 32'h0);

    // R3 zero page and absolute
    issue(4'd5, 16'hAB42, 8'h11, 8'h22, 16'h0, 16'h0042, 1'b0, 0, "R3");
    issue(4'd4, 16'h1234, 8'h11, 8'h22, 16'h0, 16'h1234, 1'b0, 0, "R3");
    // R4 zero page indexed wraps
    issue(4'd9, 16'h00F0, 8'h20, 8'h00, 16'h0, 16'h0010, 1'b0, 0, "R4");
    issue(4'd10, 16'h0080, 8'h00, 8'h7F, 16'h0, 16'h00FF, 1'b0, 0, "R4");
    issue(4'd10, 16'h00FF, 8'h00, 8'h01, 16'h0, 16'h0000, 1'b0, 0, "R4");
    // R5 absolute indexed with carry
    issue(4'd7, 16'h12F0, 8'h20, 8'h00, 16'h0, 16'h1310, 1'b0, 0, "R5");
    issue(4'd8, 16'hFFF0, 8'h00, 8'h20, 16'h0, 16'h0010, 1'b0, 0, "R5");
    // R6 relative
    issue(4'd3, 16'h0010, 8'h00, 8'h00, 16'h1000, 16'h1010, 1'b0, 0, "R6");
    issue(4'd3, 16'h00F0, 8'h00, 8'h00, 16'h1000, 16'h0FF0, 1'b0, 0, "R6");
    issue(4'd3, 16'h0020, 8'h00, 8'h00, 16'h00F0, 16'h0110, 1'b0, 0, "R6");
    issue(4'd3, 16'h0080, 8'h00, 8'h00, 16'h0010, 16'hFF90, 1'b0, 0, "R6");
    // R7 X-pre-indexed indirect
    fetchExp(16'h0015, 16'h0016);
    issue(4'd11, 16'h0010, 8'h05, 8'h00, 16'h0, ptrOf(16'h0015, 16'h0016), 1'b0, 3, "R7");
    fetchExp(16'h00FF, 16'h0000);
    issue(4'd11, 16'h00F0, 8'h0F, 8'h00, 16'h0, ptrOf(16'h00FF, 16'h0000), 1'b0, 3, "R7");
    // R8 Y-post-indexed indirect
    fetchExp(16'h00FF, 16'h0000);
    issue(4'd12, 16'h00FF, 8'h00, 8'h80, 16'h0,
          ptrOf(16'h00FF, 16'h0000) + 16'h0080, 1'b0, 3, "R8");
    fetchExp(16'h0040, 16'h0041);
    issue(4'd12, 16'h0040, 8'h00, 8'hFF, 16'h0,
          ptrOf(16'h0040, 16'h0041) + 16'h00FF, 1'b0, 3, "R8");
    // R9 absolute indirect
    fetchExp(16'h3040, 16'h3041);
    issue(4'd6, 16'h3040, 8'h00, 8'h00, 16'h0, ptrOf(16'h3040, 16'h3041), 1'b0, 3, "R9");
    // R10 pointer at last byte of a page
    issue(4'd6, 16'h30FF, 8'h00, 8'h00, 16'h0, 16'h0000, 1'b1, 0, "R10");
    // R11 modes without an address
    issue(4'd0, 16'h1234, 8'h00, 8'h00, 16'h0, 16'h0000, 1'b1, 0, "R11");
    issue(4'd1, 16'h1234, 8'h00, 8'h00, 16'h0, 16'h0000, 1'b1, 0, "R11");
    issue(4'd2, 16'h1234, 8'h00, 8'h00, 16'h0, 16'h0000, 1'b1, 0, "R11");
    issue(4'd14, 16'h1234, 8'h00, 8'h00, 16'h0, 16'h0000, 1'b1, 0, "R11");
    // R2 request raised while busy is ignored
    fetchExp(16'h0020, 16'h0021);
    issue(4'd12, 16'h0020, 8'h00, 8'h01, 16'h0,
          ptrOf(16'h0020, 16'h0021) + 16'h0001, 1'b0, 3, "R2");
    check(busy == 1'b1, "R2", "busy while fetching", {31'h0, busy}, 32'h1);
    reqMode = 4'd5; reqOperand = 16'h0077; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // drain
    while (busy || expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(extraCount == 0, "R2", "extra results or reads", extraCount, 0);
    check(expQ.size() == 0 && rdQ.size() == 0, "R2", "queues drained",
          expQ.size() + rdQ.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule